// File: doc/BRIEF.md
# Flash Programming Key-Sequence Controller

This block stands between a CPU bus and a flash array and decides when a page program may begin. Software loads bytes into a page buffer, one column at a time, through a latch-load port. The controller records which columns hold data and which page address the most recent load named. A program operation starts only after two control-register writes in a row: an arming write whose upper nibble is 5h, then a firing write whose upper nibble is Ah. The lower nibble of the firing write must equal that of the arming write.

On launch the block pulses a start strobe for one cycle. It presents the page to program together with the space and mode selections taken from the firing write, and it raises busy. Busy holds until the flash side returns a done pulse. The done pulse also empties the column-valid flags. While busy, the block ignores every control-register write and every latch load, so a second program cannot be requested or the buffer altered during an operation.

Top module: `flash_key_ctrl`

## Requirements
- R1: After reset the control register reads 00h, and busy, the start strobe and every column-valid flag are 0.
- R2: A control-register write while not busy stores bits 7:4 (key field), bit 3 (space select) and bits 2:1 (mode). The register reads back as {key, space, mode, busy}, with bit 0 being busy; bit 0 of a write has no effect.
- R3: An arming write (upper nibble 5h) followed by a firing write (upper nibble Ah, same lower nibble) raises the start strobe for exactly one cycle, in the cycle after the firing write. Busy rises in that same cycle. Idle cycles with no write may separate the two writes.
- R4: A firing write whose lower nibble differs from the armed one does not launch, and it returns the sequence to idle.
- R5: Any other write while armed aborts the sequence with no launch. This covers a control write with any upper nibble other than 5h or Ah, and any latch load, including one in the same cycle as the firing write. A new arming write while armed re-arms with its own lower nibble.
- R6: A firing write without a preceding arming write does not launch.
- R7: A latch load to byte address A (15 bits, 32 KB array, 128-byte pages) sets column-valid bit A[6:0] and records page A[14:7]. The launched page is the page of the last load before the launch.
- R8: Busy stays 1 until a done pulse arrives while busy, and reads 0 from the next cycle. A done pulse while not busy has no effect.
- R9: While busy, control-register writes and latch loads are ignored: the register readback, the column-valid flags and the recorded page are unchanged, and no launch results.
- R10: A done pulse that ends an operation clears every column-valid flag in the next cycle.
- R11: The launch space and mode outputs equal bit 3 and bits 2:1 of the firing write. They, and the launched page, hold their value while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Control-register write enable |
| cpu_wdata | input | 8 | Control-register write data |
| cpu_rdata | output | 8 | Control-register readback {key, space, mode, busy} |
| lat_wr | input | 1 | Page-buffer column latch load |
| lat_addr | input | 15 | Byte address of the latch load |
| prog_done | input | 1 | Program-complete pulse from the flash side |
| prog_start | output | 1 | One-cycle program launch strobe |
| prog_page | output | 8 | Page to be programmed |
| prog_space | output | 1 | Space select of the launch |
| prog_mode | output | 2 | Mode select of the launch |
| busy | output | 1 | Program in progress |
| col_valid | output | 128 | Per-column loaded flags of the page buffer |

## Verification
Every result of this block is registered once. A control write, latch load or done pulse on one clock edge shows up on the ports just after that edge: the readback, column-valid flags, page, start strobe and busy flag all change together. The start strobe lasts only that one cycle. The bench drives inputs on the falling edge and steps its reference model on the rising edge. It then compares every output on the following falling edge, so each result is checked in the first cycle it is due. The directed checks for launch, rejection, abort and completion look at the strobe and busy right after the firing write or the done pulse, and again one cycle later.

// File: rtl/fkc_pkg.sv
package fkc_pkg;

    localparam logic [3:0] KEY_ARM  = 4'h5;
    localparam logic [3:0] KEY_FIRE = 4'hA;

    typedef enum logic [0:0] {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } kstate_e;

endpackage

// File: rtl/fkc_keyseq.sv
module fkc_keyseq
    import fkc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       other_wr,
    input  logic       busy,
    output logic       fire,
    output logic [3:0] fire_cfg
);

    typedef struct packed {
        kstate_e    st;
        logic [3:0] nib;
    } ks_t;

    ks_t ks_q, ks_d;

    logic [3:0] hi_w;
    logic [3:0] lo_w;

    assign hi_w = wr_data[7:4];
    assign lo_w = wr_data[3:0];

    always_comb begin
        ks_d     = ks_q;
        fire     = 1'b0;
        fire_cfg = lo_w;
        if (busy) begin
            ks_d.st = KS_IDLE;
        end else begin
            case (ks_q.st)
                KS_IDLE: begin
                    if (wr_en && !other_wr && hi_w == KEY_ARM) begin
                        ks_d.st  = KS_ARMED;
                        ks_d.nib = lo_w;
                    end
                end
                KS_ARMED: begin
                    if (other_wr) begin
                        ks_d.st = KS_IDLE;
                    end else if (wr_en) begin
                        if (hi_w == KEY_FIRE && lo_w == ks_q.nib) begin
                            fire    = 1'b1;
                            ks_d.st = KS_IDLE;
                        end else if (hi_w == KEY_ARM) begin
                            ks_d.nib = lo_w;
                        end else begin
                            ks_d.st = KS_IDLE;
                        end
                    end
                end
                default: ks_d.st = KS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ks_q <= '{st: KS_IDLE, nib: 4'h0};
        end else begin
            ks_q <= ks_d;
        end
    end

    // R5: a latch load in the firing cycle never launches
    p_load_aborts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        other_wr |-> !fire);

    // R4: a nibble mismatch never launches
    p_nibble_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3:0] != ks_q.nib) |-> !fire);

    // R5: after a rejected or aborted armed cycle the sequence is idle
    p_abort_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_q.st == KS_ARMED && other_wr && !busy) |=> ks_q.st == KS_IDLE);

endmodule

// File: rtl/fkc_latch_track.sv
module fkc_latch_track #(
    parameter int ADDR_W = 15,
    parameter int COL_W  = 7,
    localparam int PAGE_W = ADDR_W - COL_W,
    localparam int NCOL   = 1 << COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              clr,
    output logic [PAGE_W-1:0] page,
    output logic [NCOL-1:0]   valid
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [NCOL-1:0]   valid;
    } lt_t;

    lt_t lt_q, lt_d;

    logic [COL_W-1:0] col_w;
    logic [NCOL-1:0]  hit_w;

    assign col_w = ld_addr[COL_W-1:0];

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        assign hit_w[c] = ld_en && (col_w == COL_W'(c));
    end

    always_comb begin
        lt_d = lt_q;
        if (clr) begin
            lt_d.valid = '0;
        end else if (ld_en) begin
            lt_d.valid = lt_q.valid | hit_w;
            lt_d.page  = ld_addr[ADDR_W-1:COL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lt_q <= '0;
        end else begin
            lt_q <= lt_d;
        end
    end

    assign page  = lt_q.page;
    assign valid = lt_q.valid;

    // R10: completion empties the buffer flags
    p_clear_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> valid == '0);

    // R7: a load records its page
    p_load_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !clr) |=> page == $past(ld_addr[ADDR_W-1:COL_W]));

    // R7: flags only grow between clears
    p_flags_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(valid) & ~valid) == '0));

endmodule

// File: rtl/fkc_ctrl_reg.sv
module fkc_ctrl_reg #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              fire,
    input  logic [3:0]        fire_cfg,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              done,
    output logic [7:0]        rdata,
    output logic              busy,
    output logic              start,
    output logic [PAGE_W-1:0] lpage,
    output logic              lspace,
    output logic [1:0]        lmode
);

    typedef struct packed {
        logic [3:0]        key;
        logic              space;
        logic [1:0]        mode;
        logic              busy;
        logic              start;
        logic [PAGE_W-1:0] lpage;
        logic              lspace;
        logic [1:0]        lmode;
    } cr_t;

    cr_t cr_q, cr_d;

    always_comb begin
        cr_d       = cr_q;
        cr_d.start = 1'b0;
        if (wr_en && !cr_q.busy) begin
            cr_d.key   = wr_data[7:4];
            cr_d.space = wr_data[3];
            cr_d.mode  = wr_data[2:1];
        end
        if (fire && !cr_q.busy) begin
            cr_d.start  = 1'b1;
            cr_d.busy   = 1'b1;
            cr_d.lpage  = page_in;
            cr_d.lspace = fire_cfg[3];
            cr_d.lmode  = fire_cfg[2:1];
        end else if (cr_q.busy && done) begin
            cr_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr_q <= '0;
        end else begin
            cr_q <= cr_d;
        end
    end

    assign rdata  = {cr_q.key, cr_q.space, cr_q.mode, cr_q.busy};
    assign busy   = cr_q.busy;
    assign start  = cr_q.start;
    assign lpage  = cr_q.lpage;
    assign lspace = cr_q.lspace;
    assign lmode  = cr_q.lmode;

    // R3: the strobe lasts one cycle
    p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R3: busy accompanies the strobe
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> busy);

    // R8: busy holds until done
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R11: launch attributes hold while busy
    p_launch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |-> ($stable(lpage) && $stable(lspace) && $stable(lmode)));

    // R9: readback frozen while busy
    p_reg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(rdata[7:1]));

endmodule

// File: rtl/flash_key_ctrl.sv
module flash_key_ctrl #(
    parameter int ARRAY_BYTES = 32768,
    parameter int PAGE_BYTES  = 128,
    localparam int ADDR_W = $clog2(ARRAY_BYTES),
    localparam int COL_W  = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - COL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_wr,
    input  logic [7:0]            cpu_wdata,
    output logic [7:0]            cpu_rdata,
    input  logic                  lat_wr,
    input  logic [ADDR_W-1:0]     lat_addr,
    input  logic                  prog_done,
    output logic                  prog_start,
    output logic [PAGE_W-1:0]     prog_page,
    output logic                  prog_space,
    output logic [1:0]            prog_mode,
    output logic                  busy,
    output logic [PAGE_BYTES-1:0] col_valid
);

    logic              fire_w;
    logic [3:0]        fire_cfg_w;
    logic              ld_ok_w;
    logic              clr_w;
    logic [PAGE_W-1:0] cur_page_w;

    assign ld_ok_w = lat_wr && !busy;
    assign clr_w   = busy && prog_done;

    fkc_keyseq u_keyseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr),
        .wr_data  (cpu_wdata),
        .other_wr (lat_wr),
        .busy     (busy),
        .fire     (fire_w),
        .fire_cfg (fire_cfg_w)
    );

    fkc_latch_track #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_ok_w),
        .ld_addr (lat_addr),
        .clr     (clr_w),
        .page    (cur_page_w),
        .valid   (col_valid)
    );

    fkc_ctrl_reg #(
        .PAGE_W (PAGE_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr),
        .wr_data  (cpu_wdata),
        .fire     (fire_w),
        .fire_cfg (fire_cfg_w),
        .page_in  (cur_page_w),
        .done     (prog_done),
        .rdata    (cpu_rdata),
        .busy     (busy),
        .start    (prog_start),
        .lpage    (prog_page),
        .lspace   (prog_space),
        .lmode    (prog_mode)
    );

    // R6: a launch always follows a firing-key write with no load
    p_start_after_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> $past(cpu_wr && cpu_wdata[7:4] == 4'hA && !lat_wr));

    // R9: no launch from writes issued while busy
    p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !prog_start);

    // R9: loads while busy leave the flags alone
    p_flags_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !prog_done) |=> $stable(col_valid));

endmodule

// File: tb/sim_flash_key_ctrl.sv
module sim_flash_key_ctrl;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_wr = 1'b0;
    logic [7:0]   cpu_wdata = 8'h00;
    logic [7:0]   cpu_rdata;
    logic         lat_wr = 1'b0;
    logic [14:0]  lat_addr = 15'h0;
    logic         prog_done = 1'b0;
    logic         prog_start;
    logic [7:0]   prog_page;
    logic         prog_space;
    logic [1:0]   prog_mode;
    logic         busy;
    logic [127:0] col_valid;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flash_key_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .lat_wr     (lat_wr),
        .lat_addr   (lat_addr),
        .prog_done  (prog_done),
        .prog_start (prog_start),
        .prog_page  (prog_page),
        .prog_space (prog_space),
        .prog_mode  (prog_mode),
        .busy       (busy),
        .col_valid  (col_valid)
    );

    // behavioural reference model
    int         m_key, m_space, m_mode, m_busy, m_start, m_page;
    int         m_lpage, m_lspace, m_lmode, m_armed, m_nib;
    bit [127:0] m_valid;
    int         launch_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_key = 0; m_space = 0; m_mode = 0; m_busy = 0; m_start = 0;
            m_page = 0; m_lpage = 0; m_lspace = 0; m_lmode = 0;
            m_armed = 0; m_nib = 0; m_valid = '0;
        end else begin
            int hi, lo, fire;
            hi = int'(cpu_wdata[7:4]);
            lo = int'(cpu_wdata[3:0]);
            fire = 0;
            if (m_busy != 0) begin
                m_armed = 0;
            end else if (m_armed != 0) begin
                if (lat_wr) m_armed = 0;
                else if (cpu_wr) begin
                    if (hi == 10 && lo == m_nib) begin fire = 1; m_armed = 0; end
                    else if (hi == 5) m_nib = lo;
                    else m_armed = 0;
                end
            end else if (cpu_wr && !lat_wr && hi == 5) begin
                m_armed = 1; m_nib = lo;
            end
            m_start = 0;
            if (m_busy == 0) begin
                if (cpu_wr) begin
                    m_key = hi; m_space = lo / 8; m_mode = (lo / 2) % 4;
                end
                if (fire != 0) begin
                    m_start = 1; m_busy = 1; m_lpage = m_page;
                    m_lspace = lo / 8; m_lmode = (lo / 2) % 4;
                    launch_q.push_back(m_page);
                end
                if (lat_wr) begin
                    m_valid[lat_addr % 128] = 1'b1;
                    m_page = lat_addr / 128;
                end
            end else if (prog_done) begin
                m_busy = 0;
                m_valid = '0;
            end
        end
    end

    function automatic int exp_rdata();
        return m_key * 16 + m_space * 8 + m_mode * 2 + m_busy;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 readback", 128'(cpu_rdata), 128'(exp_rdata()));
            chk("R3 start", 128'(prog_start), 128'(m_start));
            chk("R8 busy", 128'(busy), 128'(m_busy));
            chk("R7 col_valid", col_valid, m_valid);
            if (m_busy != 0) begin
                chk("R7 page", 128'(prog_page), 128'(m_lpage));
                chk("R11 space", 128'(prog_space), 128'(m_lspace));
                chk("R11 mode", 128'(prog_mode), 128'(m_lmode));
            end
            if (prog_start) begin
                if (launch_q.size() == 0) chk("R3 unexpected launch", 128'(1), 128'(0));
                else chk("R7 launched page", 128'(prog_page), 128'(launch_q.pop_front()));
            end
        end
    end

    // one clock of stimulus, returns at the following falling edge
    task automatic step(input bit w, input logic [7:0] d, input bit l,
                        input logic [14:0] a, input bit dn);
        cpu_wr = w; cpu_wdata = d; lat_wr = l; lat_addr = a; prog_done = dn;
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0; lat_wr = 1'b0; prog_done = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        step(1'b1, d, 1'b0, 15'h0, 1'b0);
    endtask

    task automatic ld(input logic [14:0] a);
        step(1'b0, 8'h00, 1'b1, a, 1'b0);
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 1'b0, 15'h0, 1'b0);
    endtask

    task automatic done_pulse();
        step(1'b0, 8'h00, 1'b0, 15'h0, 1'b1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", 128'(cpu_rdata), 128'h00);
        chk("R1 busy", 128'(busy), 128'(0));
        chk("R1 start", 128'(prog_start), 128'(0));
        chk("R1 col_valid", col_valid, 128'(0));

        // R2 readback, bit 0 ignored
        wr(8'h1E);
        chk("R2 write 1E", 128'(cpu_rdata), 128'h1E);
        wr(8'h0F);
        chk("R2 write 0F", 128'(cpu_rdata), 128'h0E);

        // R7 loads: page 2 col 5, then page 255 col 127
        ld(15'h0105);
        ld(15'h7FFF);
        chk("R7 flags", col_valid, (128'(1) << 5) | (128'(1) << 127));

        // R3 launch with matching nibble
        wr(8'h53);
        wr(8'hA3);
        chk("R3 start pulse", 128'(prog_start), 128'(1));
        chk("R3 busy with start", 128'(busy), 128'(1));
        chk("R7 launched page 255", 128'(prog_page), 128'hFF);
        chk("R11 space", 128'(prog_space), 128'(0));
        chk("R11 mode", 128'(prog_mode), 128'(1));
        chk("R2 rdata after launch", 128'(cpu_rdata), 128'hA3);
        idle();
        chk("R3 single pulse", 128'(prog_start), 128'(0));

        // R9 ignored while busy
        wr(8'h52);
        wr(8'hA2);
        chk("R9 no launch busy", 128'(prog_start), 128'(0));
        chk("R9 rdata frozen", 128'(cpu_rdata), 128'hA3);
        ld(15'h0010);
        chk("R9 flags frozen", col_valid, (128'(1) << 5) | (128'(1) << 127));
        chk("R11 page held", 128'(prog_page), 128'hFF);

        // R8/R10 completion
        done_pulse();
        chk("R8 busy cleared", 128'(busy), 128'(0));
        chk("R10 flags cleared", col_valid, 128'(0));
        done_pulse();
        chk("R8 stray done", 128'(busy), 128'(0));

        // R4 nibble mismatch
        ld(15'h0203);
        wr(8'h52);
        wr(8'hA3);
        chk("R4 mismatch", 128'(prog_start), 128'(0));
        wr(8'hA2);
        chk("R4 back to idle", 128'(prog_start), 128'(0));

        // R5 aborts and re-arm
        wr(8'h52); wr(8'h11); wr(8'hA2);
        chk("R5 other write aborts", 128'(prog_start), 128'(0));
        wr(8'h52); ld(15'h0304); wr(8'hA2);
        chk("R5 load aborts", 128'(prog_start), 128'(0));
        wr(8'h52);
        step(1'b1, 8'hA2, 1'b1, 15'h0400, 1'b0);
        chk("R5 same-cycle load aborts", 128'(prog_start), 128'(0));
        wr(8'h52); wr(8'h5C); wr(8'hAC);
        chk("R5 re-arm launch", 128'(prog_start), 128'(1));
        chk("R7 last page", 128'(prog_page), 128'h08);
        chk("R11 space set", 128'(prog_space), 128'(1));
        chk("R11 mode set", 128'(prog_mode), 128'(2));
        idle();
        done_pulse();
        chk("R10 cleared again", col_valid, 128'(0));

        // R6 fire without arm
        wr(8'hA2);
        chk("R6 no arm", 128'(prog_start), 128'(0));

        // R3 idle gaps allowed
        ld(15'h1234);
        wr(8'h56);
        idle(); idle(); idle();
        wr(8'hA6);
        chk("R3 gap launch", 128'(prog_start), 128'(1));
        chk("R7 gap page", 128'(prog_page), 128'h24);
        repeat (4) idle();
        chk("R8 busy holds", 128'(busy), 128'(1));
        done_pulse();
        chk("R8 busy ends", 128'(busy), 128'(0));
        idle();
        finish_run();
    end

endmodule